// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches every load and store request issued by a core. Each request carries the program counter of the instruction that issued it and the byte address it touches. A small direct-mapped history table is indexed by the low program-counter bits. For each instruction it keeps the last address it touched, the last address difference it saw and a 2-bit confidence counter. Because each instruction is learned on its own, several interleaved access streams with different strides can be followed at the same time.

When an instruction repeats the same non-zero stride often enough, the block requests a prefetch of the current address plus that stride. The request goes out on a ready/valid port toward the cache. If the cache stalls that port, a single holding register keeps the pending request, and any newer request replaces it. The block accepts a request on every cycle and never applies backpressure to the request side.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pf_valid` is 0, and every history entry is empty.
- R2: The table index is `req_pc[3:0]`. The stored tag is all PC bits above bit 3, XOR-folded into 8 bits. When an accepted request finds its entry empty, or finds a different tag there, the entry is allocated with the request's address, a zero stride and zero confidence, and no prefetch is issued.
- R3: A prefetch is issued when an instruction's address difference equals its stored non-zero stride and the confidence after the increment is 2 or more. With four accesses at a constant stride, the fourth one issues. After the clock edge that accepts the request, `pf_valid` is 1 and `pf_addr` is the request address plus the stride, modulo 2^32.
- R4: Negative strides (addresses that decrease) are learned and prefetched in the same way as positive ones.
- R5: A difference whose magnitude is at most 2048 bytes is eligible, and exactly 2048 is included. A larger difference issues nothing and resets the entry to zero stride and zero confidence, so three more matching accesses are needed before the next prefetch.
- R6: A difference that is eligible but differs from the stored stride replaces the stride and clears the confidence. Two more matching accesses are then needed before a prefetch is issued.
- R7: A zero stride never produces a prefetch, however often it repeats.
- R8: An instruction whose entry was taken over by another instruction with the same index but a different tag restarts training from zero confidence when it comes back.
- R9: Instructions that map to different indices train independently, even when their accesses interleave cycle by cycle.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, the request is held with `pf_addr` unchanged. A newly issued prefetch replaces the held one.
- R11: A handshake (`pf_valid` and `pf_ready` both 1) with no new prefetch issued in that cycle clears `pf_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A load or store request is present this cycle |
| req_pc | input | 32 | Instruction address of the request |
| req_addr | input | 32 | Byte address of the request |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | 32 | Byte address to prefetch |
| pf_ready | input | 1 | Cache accepts the prefetch request |

## Verification
Several properties are checked on every cycle. An allocation never issues a prefetch, and every issued prefetch has a non-zero, in-range stride. Every issued prefetch appears on the port one cycle later with the computed target, and the output register holds while stalled and drains after a handshake. Some behaviours can only be shown by the bench scenarios, because they depend on a whole sequence of accesses. These are the exact access on which a prefetch first appears, training starting again after an out-of-range jump, a stride change or a tag takeover, the 2048-byte boundary, and two interleaved instructions being followed at once.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
    localparam int ADDR_W     = 32;
    localparam int PC_W       = 32;
    localparam int IDX_W      = 4;
    localparam int ENTRIES    = 1 << IDX_W;
    localparam int TAG_W      = 8;
    localparam int MAX_STRIDE = 2048;
    localparam int STRIDE_W   = $clog2(MAX_STRIDE) + 2;
    localparam int CONF_W     = 2;

    localparam logic [CONF_W-1:0] CONF_FIRE = CONF_W'(2);
    localparam logic [CONF_W-1:0] CONF_TOP  = {CONF_W{1'b1}};

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic                       used;
        tag_t                       tag;
        addr_t                      last;
        logic signed [STRIDE_W-1:0] stride;
        logic [CONF_W-1:0]          conf;
    } hist_t;

    typedef enum logic [1:0] {
        UPD_ALLOC,
        UPD_RESET,
        UPD_MATCH,
        UPD_RETRAIN
    } upd_kind_t;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[IDX_W-1:0];
    endfunction

    function automatic tag_t pc_tag(input pc_t pc);
        tag_t t;
        t = '0;
        for (int i = IDX_W; i < PC_W; i++) begin
            t[(i - IDX_W) % TAG_W] = t[(i - IDX_W) % TAG_W] ^ pc[i];
        end
        return t;
    endfunction
endpackage

// File: rtl/spf_table.sv
`timescale 1ns/1ps
module spf_table
    import spf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  idx,
    input  logic  wr_en,
    input  hist_t wr_data,
    output hist_t rd_data
);
    hist_t slot [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot[idx];
endmodule

// File: rtl/spf_train.sv
`timescale 1ns/1ps
module spf_train
    import spf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  pc_t   req_pc,
    input  addr_t req_addr,
    input  hist_t cur,
    output logic  wr_en,
    output hist_t wr_data,
    output logic  issue,
    output addr_t target
);
    tag_t                       tag;
    logic                       hit;
    logic signed [ADDR_W-1:0]   delta;
    logic signed [STRIDE_W-1:0] delta_s;
    logic                       in_range;
    logic                       same;
    logic [CONF_W-1:0]          conf_next;
    upd_kind_t                  kind;

    always_comb begin
        tag       = pc_tag(req_pc);
        hit       = cur.used && (cur.tag == tag);
        delta     = req_addr - cur.last;
        delta_s   = delta[STRIDE_W-1:0];
        in_range  = (delta <= MAX_STRIDE) && (delta >= -MAX_STRIDE);
        same      = (delta_s == cur.stride);
        conf_next = (cur.conf == CONF_TOP) ? CONF_TOP : cur.conf + 1'b1;

        if (!hit)           kind = UPD_ALLOC;
        else if (!in_range) kind = UPD_RESET;
        else if (same)      kind = UPD_MATCH;
        else                kind = UPD_RETRAIN;

        wr_data.used = 1'b1;
        wr_data.tag  = tag;
        wr_data.last = req_addr;
        unique case (kind)
            UPD_MATCH: begin
                wr_data.stride = cur.stride;
                wr_data.conf   = conf_next;
            end
            UPD_RETRAIN: begin
                wr_data.stride = delta_s;
                wr_data.conf   = '0;
            end
            default: begin
                wr_data.stride = '0;
                wr_data.conf   = '0;
            end
        endcase

        wr_en  = req_valid;
        issue  = req_valid && (kind == UPD_MATCH) && (conf_next >= CONF_FIRE)
                 && (cur.stride != '0);
        target = req_addr + delta;
    end

    p_alloc_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit) |-> !issue);

    p_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        issue |-> ((target - req_addr <= ADDR_W'(MAX_STRIDE)) ||
                   (req_addr - target <= ADDR_W'(MAX_STRIDE))));

    p_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        issue |-> (target != req_addr));
endmodule

// File: rtl/spf_hold.sv
`timescale 1ns/1ps
module spf_hold
    import spf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  addr_t push_addr,
    input  logic  pf_ready,
    output logic  pf_valid,
    output addr_t pf_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else if (push) begin
            pf_valid <= 1'b1;
            pf_addr  <= push_addr;
        end else if (pf_valid && pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !push) |=> (pf_valid && $stable(pf_addr)));

    p_drain_r11: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && pf_ready && !push) |=> !pf_valid);
endmodule

// File: rtl/stride_prefetcher.sv
`timescale 1ns/1ps
module stride_prefetcher
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready
);
    idx_t  idx;
    hist_t cur;
    hist_t nxt;
    logic  wr_en;
    logic  issue;
    addr_t target;

    assign idx = pc_index(req_pc);

    spf_table u_table (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .wr_en   (wr_en),
        .wr_data (nxt),
        .rd_data (cur)
    );

    spf_train u_train (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_pc    (req_pc),
        .req_addr  (req_addr),
        .cur       (cur),
        .wr_en     (wr_en),
        .wr_data   (nxt),
        .issue     (issue),
        .target    (target)
    );

    spf_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (issue),
        .push_addr (target),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    p_target_r3: assert property (@(posedge clk) disable iff (rst)
        issue |=> (pf_valid && pf_addr == $past(target)));
endmodule

// File: tb/sim_stride_prefetcher.sv
`timescale 1ns/1ps
module sim_stride_prefetcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic        pf_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stride_prefetcher u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
        .req_addr(req_addr), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .pf_ready(pf_ready)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic expect_pf(input string what, input bit v, input logic [31:0] a);
        chk({what, " valid"}, {31'b0, pf_valid}, {31'b0, v});
        if (v) chk({what, " addr"}, pf_addr, a);
    endtask

    // Entered at a falling edge; returns at the next falling edge.
    task automatic acc(input logic [31:0] pc, input logic [31:0] addr);
        req_valid = 1'b1;
        req_pc    = pc;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        expect_pf("R1 during reset", 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        expect_pf("R1 after reset", 1'b0, '0);
    endtask

    task automatic t_forward;
        acc(32'h100, 32'h1000); expect_pf("R2 first access", 1'b0, '0);
        acc(32'h100, 32'h1200); expect_pf("R3 second", 1'b0, '0);
        acc(32'h100, 32'h1400); expect_pf("R3 third", 1'b0, '0);
        acc(32'h100, 32'h1600); expect_pf("R3 fourth issues", 1'b1, 32'h1800);
        acc(32'h100, 32'h1800); expect_pf("R3 fifth", 1'b1, 32'h1A00);
    endtask

    task automatic t_backward;
        acc(32'h204, 32'h8000); expect_pf("R4 a1", 1'b0, '0);
        acc(32'h204, 32'h7F00); expect_pf("R4 a2", 1'b0, '0);
        acc(32'h204, 32'h7E00); expect_pf("R4 a3", 1'b0, '0);
        acc(32'h204, 32'h7D00); expect_pf("R4 negative stride", 1'b1, 32'h7C00);
    endtask

    task automatic t_limit;
        acc(32'h308, 32'h0000); expect_pf("R5 a1", 1'b0, '0);
        acc(32'h308, 32'h0800); expect_pf("R5 a2", 1'b0, '0);
        acc(32'h308, 32'h1000); expect_pf("R5 a3", 1'b0, '0);
        acc(32'h308, 32'h1800); expect_pf("R5 stride 2048 eligible", 1'b1, 32'h2000);
        acc(32'h308, 32'h2001); expect_pf("R5 jump 2049 silent", 1'b0, '0);
        acc(32'h308, 32'h2801); expect_pf("R5 retrain 1", 1'b0, '0);
        acc(32'h308, 32'h3001); expect_pf("R5 retrain 2", 1'b0, '0);
        acc(32'h308, 32'h3801); expect_pf("R5 retrained", 1'b1, 32'h4001);
    endtask

    task automatic t_mismatch;
        acc(32'h40C, 32'h100); acc(32'h40C, 32'h140); acc(32'h40C, 32'h180);
        acc(32'h40C, 32'h1C0); expect_pf("R6 trained", 1'b1, 32'h200);
        acc(32'h40C, 32'h300); expect_pf("R6 stride change silent", 1'b0, '0);
        acc(32'h40C, 32'h440); expect_pf("R6 one match silent", 1'b0, '0);
        acc(32'h40C, 32'h580); expect_pf("R6 second match issues", 1'b1, 32'h6C0);
    endtask

    task automatic t_zero;
        for (int i = 0; i < 6; i++) begin
            acc(32'h501, 32'h900);
            expect_pf("R7 zero stride", 1'b0, '0);
        end
    endtask

    task automatic t_alias;
        acc(32'h602, 32'h000); acc(32'h602, 32'h080); acc(32'h602, 32'h100);
        acc(32'h602, 32'h180); expect_pf("R8 trained", 1'b1, 32'h200);
        acc(32'h702, 32'h5000); expect_pf("R8 takeover silent", 1'b0, '0);
        acc(32'h602, 32'h200); expect_pf("R8 return realloc", 1'b0, '0);
        acc(32'h602, 32'h280); expect_pf("R8 r2", 1'b0, '0);
        acc(32'h602, 32'h300); expect_pf("R8 r3", 1'b0, '0);
        acc(32'h602, 32'h380); expect_pf("R8 retrained", 1'b1, 32'h400);
    endtask

    task automatic t_interleave;
        for (int i = 0; i < 4; i++) begin
            acc(32'h803, 32'h10000 + 32'(i) * 32'h40);
            if (i == 3) expect_pf("R9 stream A", 1'b1, 32'h10100);
            else        expect_pf("R9 stream A early", 1'b0, '0);
            acc(32'h905, 32'h20000 - 32'(i) * 32'h400);
            if (i == 3) expect_pf("R9 stream B", 1'b1, 32'h1F000);
            else        expect_pf("R9 stream B early", 1'b0, '0);
        end
    endtask

    task automatic t_stall;
        pf_ready = 1'b0;
        acc(32'hA06, 32'h3000); acc(32'hA06, 32'h3100); acc(32'hA06, 32'h3200);
        acc(32'hA06, 32'h3300); expect_pf("R10 issued", 1'b1, 32'h3400);
        @(negedge clk); @(negedge clk);
        expect_pf("R10 held while stalled", 1'b1, 32'h3400);
        acc(32'hA06, 32'h3400); expect_pf("R10 overwrite", 1'b1, 32'h3500);
        pf_ready = 1'b1;
        @(negedge clk);
        expect_pf("R11 drained", 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, run hung");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_backward();
        t_limit();
        t_mismatch();
        t_zero();
        t_alias();
        t_interleave();
        t_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule